// File: doc/BRIEF.md
# Clocked Serial Shift Unit

This unit moves one byte at a time between a CPU and a serial link. The CPU writes a byte into an 8-bit shift register. If the channel is enabled, that same write starts a transfer. The unit then runs eight serial clock periods. Each falling edge presents the next bit, most significant first. Each rising edge captures one incoming bit into the low end of the register. When the eighth bit has been captured, the received byte can be read back in parallel.

The link can use separate data pins, a serial output and a serial input. It can also use one shared open-drain data line. On the shared line, a receiving unit loads all ones before the transfer, so its driver never pulls the line low and the remote sender controls the level. Bus mode also has a busy condition. With busy-enable set, the busy condition is raised when each byte completes. The next CPU data write releases it and does not change busy-enable.

The serial clock comes from one of two sources. It can be made internally by dividing the system clock, or it can be taken from an external clock pin through a synchronizer. A small state machine with five states sequences the transfer:
- IDLE waits for a write.
- ARM holds the clock high for a lead-in half period, or waits for the first external falling edge.
- DRIVE holds the clock low after a falling edge.
- SAMPLE holds the clock high after a rising edge.
- DONE lasts one cycle and marks completion.

The transitions are as follows:
- IDLE goes to ARM on an accepted write with the channel enabled.
- ARM goes to DRIVE on a tick.
- DRIVE goes to SAMPLE on a tick, or to DONE if that tick captures the last bit.
- SAMPLE goes to DRIVE on a tick.
- DONE goes to ARM on an accepted enabled write, and otherwise to IDLE.

Top module: `ser_shift_unit`

## Requirements
- R1: After reset the unit is idle, `sck_out` is 1, `so` is 1, `sda_oe` is 0, `done` is 0 and `busy` is 0. The contents of the shift register are not defined until the first data write.
- R2: A control write (`ctl_wr`) loads four bits. Bit 0 is channel enable, bit 1 is bus mode, bit 2 is busy-enable and bit 3 is external clock. With channel enable at 0, a data write only loads `rd_data`, and no serial clock edge or `done` pulse follows.
- R3: With the internal clock and channel enable at 1, the data write is sampled at clock edge e. `sck_out` falls at edges e+DIV_HALF, e+3·DIV_HALF and so on, and rises at e+2·DIV_HALF, e+4·DIV_HALF and so on, for eight periods in total.
- R4: At each falling serial clock edge, the serial output presents the next bit of the written byte, most significant bit first. It does not change at any other time during a transfer.
- R5: At each rising serial clock edge, the selected input bit is shifted into bit 0 of the register. After the eighth rising edge, `rd_data` holds the received byte.
- R6: `done` is high for exactly one cycle, the cycle after the eighth rising edge. The serial clock then stays high until the next write.
- R7: In bus mode, `so` is held at 1, `sda_oe` is 1 only while the current output bit is 0, and input bits come from `sda_in` instead of `si`.
- R8: In bus mode, a receiver that has loaded 0xFF never asserts `sda_oe`, and it receives the byte placed on the line by the remote sender.
- R9: In bus mode with busy-enable at 1, `busy` is set when a byte completes. Any data write in bus mode clears it. Busy-enable keeps its value, so the next byte sets `busy` again with no new control write.
- R10: Data writes and control writes that arrive while a transfer is in progress (states ARM, DRIVE or SAMPLE) are ignored.
- R11: With external clock selected, edges are taken from `sck_in` after a two-stage synchronizer and `sck_out` stays at 1. The byte is exchanged in the same order as with the internal clock.
- R12: After a transfer ends, the serial output returns to 1, which releases the shared line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 4 | Control bits: channel enable, bus mode, busy-enable, external clock |
| wr_en | input | 1 | Data write strobe; loads the register and may start a transfer |
| wr_data | input | 8 | Byte written by the CPU |
| rd_data | output | 8 | Parallel view of the shift register |
| si | input | 1 | Serial input on separate pins |
| so | output | 1 | Serial output on separate pins |
| sda_in | input | 1 | Level seen on the shared data line |
| sda_oe | output | 1 | Pull the shared data line low when 1 |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internally generated serial clock |
| done | output | 1 | One-cycle transfer-complete pulse |
| busy | output | 1 | Bus busy condition |

## Verification
The hardest state to reach from the ports is a busy condition that sets again on a second byte with no new control write. To get there, the stimulus runs a 0xFF receive in bus mode, then releases busy with a transmit write, and lets that transfer finish while busy-enable is left untouched. A second hard case is a pair of writes in the middle of a transfer, one to data and one to control. The bench issues both while the clock is running. It then confirms that the received byte, the timing and the channel enable are unchanged by restarting at once. The external-clock path is driven by slow edges from the bench, and the bench captures the output bits at its own rising edges.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_DRIVE,
        S_SAMPLE,
        S_DONE
    } ssu_state_t;

    typedef struct packed {
        logic ext_clk;
        logic busy_en;
        logic bus_mode;
        logic chan_en;
    } ssu_cfg_t;

endpackage

// File: rtl/ssu_clkgen.sv
module ssu_clkgen #(
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic sck_in,
    input  logic run,
    input  logic want_rise,
    output logic tick
);
    localparam int DCW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DCW-1:0] DIV_LAST = DCW'(DIV_HALF - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [DCW-1:0]         div_q;
    logic                   ext_rise, ext_fall, div_hit;

    // external clock synchronizer, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign ext_fall = ~sync_q[SYNC_STAGES-1] & prev_q;

    // internal half-period divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  div_q <= '0;
        else if (!run || ext_sel)    div_q <= '0;
        else if (div_q == DIV_LAST)  div_q <= '0;
        else                         div_q <= div_q + 1'b1;
    end

    assign div_hit = run && (div_q == DIV_LAST);

    always_comb begin
        if (ext_sel) tick = run & (want_rise ? ext_rise : ext_fall);
        else         tick = div_hit;
    end

endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              fall_stb,
    input  logic              rise_stb,
    input  logic              finish,
    input  logic              sin,
    output logic [DATA_W-1:0] sreg_o,
    output logic              out_o
);
    logic [DATA_W-1:0] sreg_q;
    logic              out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sreg_q <= '0;
        else if (load)     sreg_q <= load_data;
        else if (rise_stb) sreg_q <= {sreg_q[DATA_W-2:0], sin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_q <= 1'b1;
        else if (finish)   out_q <= 1'b1;
        else if (fall_stb) out_q <= sreg_q[DATA_W-1];
    end

    assign sreg_o = sreg_q;
    assign out_o  = out_q;

    // R4: output bit moves only at a falling strobe or at the end of a byte
    p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_stb && !finish) |=> $stable(out_q));

endmodule

// File: rtl/ssu_ctrl.sv
module ssu_ctrl
    import ssu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_wr,
    input  logic [3:0] ctl_data,
    input  logic     wr_en,
    input  logic     tick,
    output ssu_cfg_t cfg_o,
    output logic     accept,
    output logic     run,
    output logic     want_rise,
    output logic     fall_stb,
    output logic     rise_stb,
    output logic     finish,
    output logic     sck_o,
    output logic     done_o,
    output logic     busy_o
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    ssu_state_t       state_q, state_d;
    ssu_cfg_t         cfg_q;
    logic [CNT_W-1:0] bit_q;
    logic             sck_q, busy_q;

    assign run       = (state_q == S_ARM) || (state_q == S_DRIVE) || (state_q == S_SAMPLE);
    assign accept    = wr_en && !run;
    assign want_rise = (state_q == S_DRIVE);
    assign fall_stb  = tick && ((state_q == S_ARM) || (state_q == S_SAMPLE));
    assign rise_stb  = tick && (state_q == S_DRIVE);
    assign finish    = rise_stb && (bit_q == LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept && cfg_q.chan_en) state_d = S_ARM;
            S_ARM:    if (tick) state_d = S_DRIVE;
            S_DRIVE:  if (tick) state_d = (bit_q == LAST_BIT) ? S_DONE : S_SAMPLE;
            S_SAMPLE: if (tick) state_d = S_DRIVE;
            S_DONE:   state_d = (accept && cfg_q.chan_en) ? S_ARM : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            bit_q  <= '0;
            sck_q  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            if (ctl_wr && !run) cfg_q <= ctl_data;
            if (accept)         bit_q <= '0;
            else if (rise_stb)  bit_q <= bit_q + 1'b1;
            if (fall_stb && !cfg_q.ext_clk)      sck_q <= 1'b0;
            else if (rise_stb || !run)           sck_q <= 1'b1;
            if (accept && cfg_q.bus_mode)        busy_q <= 1'b0;
            else if (finish && cfg_q.bus_mode && cfg_q.busy_en) busy_q <= 1'b1;
        end
    end

    assign cfg_o  = cfg_q;
    assign sck_o  = sck_q;
    assign done_o = (state_q == S_DONE);
    assign busy_o = busy_q;

    // R6: completion pulse lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: clock parked high whenever idle
    p_clock_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> sck_q);
    // R10: control register frozen while a transfer runs
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(cfg_q));
    // R9: a bus-mode data write always releases busy
    p_busy_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_q.bus_mode) |=> !busy_q);
    // R11: external clock mode never drives the clock low
    p_ext_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.ext_clk |=> sck_q);

endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit
    import ssu_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [3:0]        ctl_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              si,
    output logic              so,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              done,
    output logic              busy
);
    ssu_cfg_t cfg;
    logic accept, run, want_rise, fall_stb, rise_stb, finish, tick;
    logic out_bit, rx_bit;

    ssu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .wr_en(wr_en), .tick(tick), .cfg_o(cfg), .accept(accept), .run(run),
        .want_rise(want_rise), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .finish(finish), .sck_o(sck_out), .done_o(done), .busy_o(busy)
    );

    ssu_clkgen #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .ext_sel(cfg.ext_clk), .sck_in(sck_in),
        .run(run), .want_rise(want_rise), .tick(tick)
    );

    assign rx_bit = cfg.bus_mode ? sda_in : si;

    ssu_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_data(wr_data),
        .fall_stb(fall_stb), .rise_stb(rise_stb), .finish(finish),
        .sin(rx_bit), .sreg_o(rd_data), .out_o(out_bit)
    );

    assign so     = cfg.bus_mode ? 1'b1 : out_bit;
    assign sda_oe = cfg.bus_mode & ~out_bit;

    // R12: line released in the cycle after completion
    p_release_after_r12: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (so && !sda_oe));
    // R3: no serial activity while the unit is not running
    p_no_edge_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!fall_stb && !rise_stb));

endmodule

// File: tb/tb_ser_shift_unit.sv
`timescale 1ns/1ps
module tb_ser_shift_unit;
    localparam int H = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_wr = 0, wr_en = 0, sck_in = 1;
    logic [3:0] ctl_data = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic so, sda_oe, sck_out, done, busy, si, sda_in;
    logic si_rand = 0, line_rand = 1, ext_bit = 0;
    int   si_mode = 0;

    always #4 clk = ~clk;

    assign si     = (si_mode == 0) ? si_rand : (si_mode == 1) ? 1'b1 :
                    (si_mode == 2) ? 1'b0 : ext_bit;
    assign sda_in = line_rand & ~sda_oe;

    ser_shift_unit #(.DATA_W(8), .DIV_HALF(H), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .si(si), .so(so),
        .sda_in(sda_in), .sda_oe(sda_oe), .sck_in(sck_in), .sck_out(sck_out),
        .done(done), .busy(busy)
    );

    int checks = 0, failures = 0;
    bit finished = 0, ext_mode = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    bit m_active, m_done, m_busy, m_loaded, m_sck, m_out;
    bit m_chan, m_bus, m_ben, m_ext;
    logic [7:0] m_sreg;
    int m_t;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_done = 0; m_busy = 0; m_loaded = 0; m_sck = 1; m_out = 1;
            m_chan = 0; m_bus = 0; m_ben = 0; m_ext = 0; m_sreg = 0; m_t = 0;
        end else begin
            bit was_active, inb;
            was_active = m_active;
            inb = m_bus ? sda_in : si;
            m_done = 0;
            if (m_active) begin
                m_t++;
                if (m_t % H == 0) begin
                    int n;
                    n = m_t / H;
                    if (n % 2 == 1) begin
                        m_sck = 0; m_out = m_sreg[7];
                    end else begin
                        m_sck = 1; m_sreg = {m_sreg[6:0], inb};
                        if (n == 16) begin
                            m_active = 0; m_done = 1; m_out = 1;
                            if (m_bus && m_ben) m_busy = 1;
                        end
                    end
                end
            end else if (wr_en) begin
                m_sreg = wr_data; m_loaded = 1;
                if (m_bus) m_busy = 0;
                if (m_chan && !m_ext) begin m_active = 1; m_t = 0; end
            end
            if (ctl_wr && !was_active) begin
                m_chan = ctl_data[0]; m_bus = ctl_data[1];
                m_ben = ctl_data[2]; m_ext = ctl_data[3];
            end
        end
    end

    // stimulus noise and monitors
    int done_cnt = 0;
    bit oe_seen = 0, sck_low_seen = 0;
    always @(negedge clk) begin
        si_rand   <= $urandom;
        line_rand <= $urandom;
        if (done) done_cnt++;
        if (sda_oe) oe_seen = 1;
        if (!sck_out) sck_low_seen = 1;
        if (rst_n && !ext_mode) begin
            chk(sck_out == m_sck, "R3 sck_out", sck_out, m_sck);
            chk(so == (m_bus ? 1'b1 : m_out), "R4 so", so, m_bus ? 1'b1 : m_out);
            chk(sda_oe == (m_bus & ~m_out), "R7 sda_oe", sda_oe, m_bus & ~m_out);
            chk(done == m_done, "R6 done", done, m_done);
            chk(busy == m_busy, "R9 busy", busy, m_busy);
            if (m_loaded) chk(rd_data == m_sreg, "R5 rd_data", rd_data, m_sreg);
        end
    end

    task automatic ctl(input logic [3:0] v);
        @(negedge clk); ctl_wr = 1; ctl_data = v;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R3 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int d0;
        logic [7:0] cap;
        cyc(3);
        // R1 reset state
        chk(sck_out == 1 && so == 1 && sda_oe == 0 && done == 0 && busy == 0,
            "R1 reset outputs", {sck_out, so, sda_oe, done, busy}, 5'b11000);
        rst_n = 1;
        cyc(2);

        // R2 load only
        ctl(4'b0000);
        d0 = done_cnt; sck_low_seen = 0;
        wr(8'h5A);
        cyc(40);
        chk(rd_data == 8'h5A, "R2 load only data", rd_data, 8'h5A);
        chk(done_cnt == d0 && !sck_low_seen, "R2 no transfer", done_cnt - d0, 0);

        // R3..R6 random input
        ctl(4'b0001);
        d0 = done_cnt;
        wr(8'hA5);
        cyc(80);
        chk(done_cnt == d0 + 1, "R6 one pulse", done_cnt - d0, 1);
        chk(so == 1, "R12 so idle high", so, 1);

        // R5 fixed input patterns
        si_mode = 1; wr(8'h00); cyc(80);
        chk(rd_data == 8'hFF, "R5 all ones in", rd_data, 8'hFF);
        si_mode = 2; wr(8'hFF); cyc(80);
        chk(rd_data == 8'h00, "R5 all zeros in", rd_data, 8'h00);
        si_mode = 0;

        // R10 writes during transfer
        wr(8'h3C);
        cyc(20);
        wr(8'h11);
        ctl(4'b0000);
        cyc(60);
        sck_low_seen = 0;
        wr(8'h0F);
        cyc(10);
        chk(sck_low_seen, "R10 channel enable kept", sck_low_seen, 1);
        cyc(70);

        // R7 R8 R9 bus mode
        ctl(4'b0111);
        oe_seen = 0; d0 = done_cnt;
        wr(8'hFF);
        cyc(80);
        chk(!oe_seen, "R8 preload never drives", oe_seen, 0);
        chk(busy == 1, "R9 busy set", busy, 1);
        wr(8'h96);
        @(negedge clk);
        chk(busy == 0, "R9 busy released by write", busy, 0);
        cyc(80);
        chk(busy == 1, "R9 busy_en retained", busy, 1);
        chk(done_cnt == d0 + 2, "R6 two bus bytes", done_cnt - d0, 2);
        wr(8'hC3);
        cyc(80);

        // R11 external clock
        ctl(4'b1001);
        cyc(2);
        ext_mode = 1; si_mode = 3; sck_low_seen = 0; d0 = done_cnt; cap = 0;
        wr(8'hA5);
        cyc(4);
        for (int i = 0; i < 8; i++) begin
            sck_in = 0; cyc(8);
            cap = {cap[6:0], so};
            ext_bit = (8'h3C >> (7 - i)) & 1'b1;
            sck_in = 1; cyc(8);
        end
        cyc(6);
        chk(cap == 8'hA5, "R11 ext transmit order", cap, 8'hA5);
        chk(rd_data == 8'h3C, "R11 ext receive", rd_data, 8'h3C);
        chk(done_cnt == d0 + 1, "R11 ext done", done_cnt - d0, 1);
        chk(!sck_low_seen, "R11 sck_out held", sck_low_seen, 0);
        chk(so == 1, "R12 released after ext", so, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule